// File: doc/BRIEF.md
# Completion Status Queue

This block keeps a short first-in first-out record of the results a copy or messaging engine reports, one queue for each processor. Each time the engine finishes an operation it presents one result: a two-bit index that software chose for the operation, a four-bit completion code, the identity of the controller and crossbar port that saw an error, a five-bit error code and a 22-bit residual length. The queue stores the result. A software read of the status register takes the oldest result out of the queue and returns it.

The word that a read returns also carries a valid flag and a sticky overflow flag. Valid shows whether the word holds a result. Overflow shows that at least one result arrived while every slot was taken, so that result was lost. A read clears the overflow flag. Register writes that reach this address leave the queue unchanged.

If a result arrives in the same cycle that a read frees a slot in a full queue, the result is accepted and nothing is lost.

Top module: `cstat_queue`

## Requirements
- R1: After reset the read word is all zeros. Valid (bit 0) is 0, overflow (bit 1) is 0 and every field is 0.
- R2: Results come out in the order they were pushed. The word for the head entry has valid=1 at bit 0, overflow at bit 1, index at [3:2], completion code at [7:4], controller at [9:8], port at [13:10], error code at [18:14] and residual at [63:42]. All other bits are 0.
- R3: A read in a cycle removes the head entry. After that read, valid stays 1 if at least one entry remains and becomes 0 once the last entry has been read.
- R4: A result pushed while the queue holds DEPTH entries and no read happens in the same cycle is discarded. Overflow becomes 1 and the entries already stored do not change.
- R5: Any read clears overflow from the next cycle on, unless a result is discarded in that same cycle.
- R6: A push and a read in the same cycle on a full queue remove the head and store the new result. The queue stays full and overflow is not set.
- R7: A result with completion code 0 (success) is stored with the residual field all ones, whatever value the engine drives. Any other code stores the residual value as given.
- R8: A register write strobe (wr_i) has no effect: the read word and the queue contents do not change.
- R9: A read of an empty queue returns a word with valid=0 and all fields 0. It removes nothing and does not disturb later pushes.
- R10: A push and a read in the same cycle on a queue that is neither empty nor full both take effect, so the number of entries stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Engine presents one result this cycle |
| push_idx_i | input | 2 | Index that software chose for the operation |
| push_code_i | input | 4 | Completion code (0 = success) |
| push_ctrl_i | input | 2 | Controller that detected the error |
| push_port_i | input | 4 | Crossbar port that detected the error |
| push_err_i | input | 5 | Error code |
| push_resid_i | input | 22 | Remaining length when the operation was aborted |
| rd_i | input | 1 | Register read strobe; removes the head entry |
| wr_i | input | 1 | Register write strobe; ignored |
| rd_data_o | output | 64 | Read word: head entry with valid and overflow flags |

## Verification
The bench builds the block with DEPTH=4. At this depth a few cycles are enough to take the queue from empty to full to overflow and back. The pointers also wrap many times during a run of a few thousand cycles. A pseudo-random sweep changes the balance between pushes and reads from phase to phase, so the queue passes through every fill level. It also reaches every overlap of push, read and write at each level, including the full-queue swap and a read of an empty queue. The word expected in each cycle comes from a small arithmetic model of the queue.

// File: rtl/cstat_pkg.sv
package cstat_pkg;

    localparam int IDX_W   = 2;
    localparam int CODE_W  = 4;
    localparam int CTRL_W  = 2;
    localparam int PORT_W  = 4;
    localparam int ERR_W   = 5;
    localparam int RESID_W = 22;
    localparam int WORD_W  = 64;

    // read word layout
    localparam int VLD_B     = 0;
    localparam int OVF_B     = 1;
    localparam int IDX_LSB   = 2;
    localparam int CODE_LSB  = 4;
    localparam int CTRL_LSB  = 8;
    localparam int PORT_LSB  = 10;
    localparam int ERR_LSB   = 14;
    localparam int RESID_LSB = WORD_W - RESID_W;

    typedef enum logic [CODE_W-1:0] {
        CC_OK      = 4'd0,
        CC_MOVER   = 4'd1,
        CC_SRC_MEM = 4'd2,
        CC_DST_MEM = 4'd3,
        CC_SRC_XLT = 4'd4,
        CC_DST_XLT = 4'd5,
        CC_ALLOC   = 4'd6,
        CC_CMPL    = 4'd7
    } cmpl_code_e;

    typedef enum logic [ERR_W-1:0] {
        EC_PURGE    = 5'd0,
        EC_NO_QSPC  = 5'd1,
        EC_NO_MEM   = 5'd2,
        EC_RX_OFF   = 5'd3,
        EC_SRC_XLT  = 5'd4,
        EC_DST_XLT  = 5'd5,
        EC_TIMEOUT  = 5'd6
    } err_code_e;

    typedef struct packed {
        logic [IDX_W-1:0]   idx;
        logic [CODE_W-1:0]  code;
        logic [CTRL_W-1:0]  ctrl;
        logic [PORT_W-1:0]  port;
        logic [ERR_W-1:0]   err;
        logic [RESID_W-1:0] resid;
    } cstat_entry_t;

endpackage

// File: rtl/cstat_admit.sv
module cstat_admit
    import cstat_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             rd_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             do_push_o,
    output logic             do_pop_o,
    output logic             ovf_o
);

    typedef struct packed {
        logic ovf;
    } adm_state_t;

    adm_state_t s_d, s_q;
    logic empty_d, full_d, drop_d;

    always_comb begin
        s_d       = s_q;
        empty_d   = (count_i == '0);
        full_d    = (count_i == CNT_W'(DEPTH));
        do_pop_o  = rd_i && !empty_d;
        do_push_o = push_i && (!full_d || do_pop_o);
        drop_d    = push_i && !do_push_o;
        if (drop_d) begin
            s_d.ovf = 1'b1;
        end else if (rd_i) begin
            s_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ovf_o = s_q.ovf;

    // R4
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !rd_i && count_i == CNT_W'(DEPTH)) |=> ovf_o);

    // R5
    ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> !ovf_o);

endmodule

// File: rtl/cstat_store.sv
module cstat_store
    import cstat_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_push_i,
    input  logic             do_pop_i,
    input  cstat_entry_t     entry_i,
    output cstat_entry_t     head_o,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        cstat_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]         wp;
        logic [PTR_W-1:0]         rp;
        logic [CNT_W-1:0]         cnt;
    } store_state_t;

    store_state_t s_d, s_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (do_push_i) begin
            s_d.mem[s_q.wp] = entry_i;
            s_d.wp          = ptr_next(s_q.wp);
        end
        if (do_pop_i) begin
            s_d.rp = ptr_next(s_q.rp);
        end
        case ({do_push_i, do_pop_i})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_o  = s_q.mem[s_q.rp];
    assign count_o = s_q.cnt;

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(DEPTH));

    // R3
    pop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pop_i && !do_push_i) |=> (count_o == $past(count_o) - 1'b1));

endmodule

// File: rtl/cstat_pack.sv
module cstat_pack
    import cstat_pkg::*;
(
    input  logic              valid_i,
    input  logic              ovf_i,
    input  cstat_entry_t      head_i,
    output logic [WORD_W-1:0] word_o
);

    always_comb begin
        word_o        = '0;
        word_o[VLD_B] = valid_i;
        word_o[OVF_B] = ovf_i;
        if (valid_i) begin
            word_o[IDX_LSB   +: IDX_W]   = head_i.idx;
            word_o[CODE_LSB  +: CODE_W]  = head_i.code;
            word_o[CTRL_LSB  +: CTRL_W]  = head_i.ctrl;
            word_o[PORT_LSB  +: PORT_W]  = head_i.port;
            word_o[ERR_LSB   +: ERR_W]   = head_i.err;
            word_o[RESID_LSB +: RESID_W] = head_i.resid;
        end
    end

endmodule

// File: rtl/cstat_queue.sv
module cstat_queue
    import cstat_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [1:0]   push_idx_i,
    input  logic [3:0]   push_code_i,
    input  logic [1:0]   push_ctrl_i,
    input  logic [3:0]   push_port_i,
    input  logic [4:0]   push_err_i,
    input  logic [21:0]  push_resid_i,
    input  logic         rd_i,
    input  logic         wr_i,
    output logic [63:0]  rd_data_o
);

    cstat_entry_t     entry_d;
    cstat_entry_t     head_q;
    logic [CNT_W-1:0] count_q;
    logic             do_push, do_pop, ovf_q;

    always_comb begin
        entry_d.idx   = push_idx_i;
        entry_d.code  = push_code_i;
        entry_d.ctrl  = push_ctrl_i;
        entry_d.port  = push_port_i;
        entry_d.err   = push_err_i;
        entry_d.resid = (push_code_i == CC_OK) ? '1 : push_resid_i;
    end

    cstat_admit #(.DEPTH(DEPTH)) u_admit (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .rd_i      (rd_i),
        .count_i   (count_q),
        .do_push_o (do_push),
        .do_pop_o  (do_pop),
        .ovf_o     (ovf_q)
    );

    cstat_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_push_i (do_push),
        .do_pop_i  (do_pop),
        .entry_i   (entry_d),
        .head_o    (head_q),
        .count_o   (count_q)
    );

    cstat_pack u_pack (
        .valid_i (count_q != '0),
        .ovf_i   (ovf_q),
        .head_i  (head_q),
        .word_o  (rd_data_o)
    );

    // R7
    ok_resid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[VLD_B] && rd_data_o[CODE_LSB +: CODE_W] == CC_OK)
        |-> (rd_data_o[RESID_LSB +: RESID_W] == '1));

    // R6
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && rd_i && count_q == CNT_W'(DEPTH))
        |=> (count_q == CNT_W'(DEPTH) && !ovf_q));

    // R8
    write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !push_i && !rd_i) |=> $stable(rd_data_o));

endmodule

// File: tb/sim_cstat_queue.sv
`timescale 1ns/1ps
module sim_cstat_queue;

    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0;
    logic [1:0]  push_idx_i = '0;
    logic [3:0]  push_code_i = '0;
    logic [1:0]  push_ctrl_i = '0;
    logic [3:0]  push_port_i = '0;
    logic [4:0]  push_err_i = '0;
    logic [21:0] push_resid_i = '0;
    logic        rd_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [63:0] rd_data_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cstat_queue #(.DEPTH(D)) u0 (.*);

    // model: entries {idx,code,ctrl,port,err,resid} = 39 bits
    logic [38:0] mq [D];
    int hd = 0, cnt = 0;
    bit ovf = 0;

    function automatic logic [38:0] mk(input int k);
        logic [3:0]  c = 4'(k);
        logic [21:0] r = 22'(k * 37 + 5);
        return {2'(k >> 1), c, 2'(k >> 4), 4'(k >> 6), 5'(k >> 10), r};
    endfunction

    function automatic logic [63:0] pack(input bit v, input bit o, input logic [38:0] e);
        logic [63:0] w = '0;
        w[0] = v;
        w[1] = o;
        if (v) begin
            w[3:2]   = e[38:37];
            w[7:4]   = e[36:33];
            w[9:8]   = e[32:31];
            w[13:10] = e[30:27];
            w[18:14] = e[26:22];
            w[63:42] = e[21:0];
        end
        return w;
    endfunction

    task automatic check(input logic [63:0] exp, input string tag);
        n_vec++;
        if (rd_data_o !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, rd_data_o, exp);
        end
    endtask

    task automatic step(input bit p, input int k, input bit r, input bit w, input string tag);
        logic [38:0] e;
        bit pop, acc;
        int tail;
        @(negedge clk);
        e = mk(k);
        push_i = p; rd_i = r; wr_i = w;
        {push_idx_i, push_code_i, push_ctrl_i, push_port_i, push_err_i, push_resid_i} = e;
        #1;
        check(pack(cnt > 0, ovf, mq[hd]), tag);
        if (e[36:33] == 4'd0) e[21:0] = '1;   // success stores all-ones residual
        tail = (hd + cnt) % D;
        pop = r && cnt > 0;
        acc = p && (cnt < D || pop);
        if (pop) hd = (hd + 1) % D;
        if (acc) mq[tail] = e;
        cnt = cnt + int'(acc) - int'(pop);
        if (p && !acc) ovf = 1;
        else if (r) ovf = 0;
    endtask

    initial begin
        for (int i = 0; i < D; i++) mq[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        check(64'h0, "R1");
        rst_n = 1'b1;
        // fill in order
        for (int k = 1; k <= D; k++) step(1, k, 0, 0, "R2");
        // discard while full
        step(1, 200, 0, 0, "R4");
        step(0, 0, 0, 1, "R4");
        step(1, 201, 0, 1, "R8");
        step(0, 0, 0, 1, "R8");
        // read clears overflow
        step(0, 0, 1, 0, "R5");
        step(0, 0, 0, 0, "R5");
        step(1, 5, 0, 0, "R2");
        // swap on a full queue
        step(1, 6, 1, 0, "R6");
        step(1, 7, 1, 0, "R6");
        step(0, 0, 0, 0, "R6");
        // drain
        for (int k = 0; k < D; k++) step(0, 0, 1, 0, "R3");
        step(0, 0, 1, 0, "R9");
        step(0, 0, 1, 1, "R9");
        step(1, 16, 1, 0, "R9");
        step(1, 32, 0, 0, "R7");
        step(1, 34, 1, 0, "R10");
        step(1, 35, 1, 0, "R10");
        step(0, 0, 1, 0, "R7");
        step(0, 0, 1, 0, "R3");
        step(0, 0, 0, 0, "R3");
        // sweep with phase-biased traffic
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 4000; i++) begin
                bit ph = (i / 250) % 2 == 1;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(ph ? (lf[1:0] != 0) : (lf[1:0] == 0),
                     i + 100,
                     ph ? (lf[3:2] == 0) : (lf[3:2] != 0),
                     lf[4], "R10");
            end
        end
        @(negedge clk);
        push_i = 0; rd_i = 0; wr_i = 0;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule